// File: doc/BRIEF.md
# Oversampling Baud Tick Generator

This block derives the 16x oversampling tick of an asynchronous serial engine from the module clock. A 13-bit reload down-counter sets the final division. The counter advances on an enable that comes from one of two sources. One is a fixed prescaler that divides the clock by 2 or by 3. The other is a fractional phase accumulator that passes on average fdv out of every 8192 clocks.

Software programs the block through a small write-only register bus. Address 0 holds the control bits: run in bit 0, divide-by-3 select in bit 1 and fractional mode in bit 2. Address 1 holds the reload value in the low 13 bits. Address 2 holds the fractional numerator fdv in the low 13 bits. The reload register is locked while the generator runs, so the divisor can only be changed by stopping, writing and restarting. Each tick is a single-cycle pulse on `tick`.

Top module: `baud_frac_gen`

## Requirements
- R1: After reset, `tick` is low and every register is zero: stopped, divide-by-2, prescaler mode, reload 0, fdv 0. Setting only the run bit then gives a tick every 2 cycles.
- R2: In prescaler mode with bit 1 of the control word clear, ticks repeat every 2 × (reload + 1) clocks.
- R3: In prescaler mode with bit 1 of the control word set, ticks repeat every 3 × (reload + 1) clocks.
- R4: With bit 2 of the control word set, the counter advances on each carry of a 13-bit accumulator that adds fdv every clock. The average tick period is therefore 8192 × (reload + 1) / fdv clocks, and fdv = 0 gives no ticks at all.
- R5: A write to the reload register (address 1) while the run bit is 1 is ignored and leaves the tick period unchanged, including after a later stop and restart.
- R6: While the run bit is 0, `tick` stays low, and the prescaler and the accumulator are cleared, so every restart behaves the same way.
- R7: When the run bit rises, the counter loads the reload value. In prescaler mode the first tick appears P × (reload + 1) clocks after the clock edge that stores the run bit, where P is 2 or 3.
- R8: In prescaler mode each tick is exactly one clock cycle wide.
- R9: The reload field is 13 bits wide. Bits above bit 12 of the write data are dropped, and the maximum reload of 8191 gives a period of 16384 clocks at divide-by-2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 control, 1 reload, 2 fdv |
| bus_wdata | input | DATA_W | Write data |
| tick | output | 1 | One-cycle 16x oversampling tick |

## Verification
The bench measures the latency to the first tick and the gaps between later ticks at both prescaler ratios. An off-by-one in the prescaler or in the reload reload-on-zero shifts both numbers, and a swapped select bit turns a 15-cycle period into 10. The fractional mode is run with numerators that give exactly periodic patterns (one half and three quarters) and with zero. A design that failed to carry, or that stepped on every clock, would give the wrong gap or a stray tick. The bench writes a new reload while the generator runs and then stops and restarts it. A design that did not lock the register would show the shorter period. Restarting after a stop mid-count exposes a prescaler or accumulator that keeps stale state, and the all-ones write exposes a reload field that is too narrow or too wide.

// File: rtl/baud_frac_gen.sv
module baud_frac_gen #(
  parameter int CNT_W  = 13,
  parameter int FRAC_W = 13,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              tick
);
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_RELD = 2'd1;
  localparam logic [1:0] A_FDV  = 2'd2;

  logic              run_q, run_d, div3_q, frac_q;
  logic [CNT_W-1:0]  reload_q, cnt_q;
  logic [FRAC_W-1:0] fdv_q, acc_q;
  logic [1:0]        pre_q;
  logic [FRAC_W:0]   sum;
  logic              pre_last, step, at_zero, tick_q;

  assign sum      = {1'b0, acc_q} + {1'b0, fdv_q};
  assign pre_last = (pre_q == (div3_q ? 2'd2 : 2'd1));
  assign step     = frac_q ? sum[FRAC_W] : pre_last;
  assign at_zero  = (cnt_q == '0);
  assign tick     = tick_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      div3_q   <= 1'b0;
      frac_q   <= 1'b0;
      reload_q <= '0;
      fdv_q    <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_CTRL: begin
          run_q  <= bus_wdata[0];
          div3_q <= bus_wdata[1];
          frac_q <= bus_wdata[2];
        end
        A_RELD: if (!run_q) reload_q <= bus_wdata[CNT_W-1:0];
        A_FDV:  fdv_q <= bus_wdata[FRAC_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_d  <= 1'b0;
      pre_q  <= '0;
      acc_q  <= '0;
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      run_d  <= run_q;
      tick_q <= 1'b0;
      if (!run_q) begin
        pre_q <= '0;
        acc_q <= '0;
      end else begin
        pre_q <= pre_last ? 2'd0 : pre_q + 2'd1;
        acc_q <= sum[FRAC_W-1:0];
        if (!run_d) begin
          cnt_q <= reload_q;
        end else if (step) begin
          if (at_zero) begin
            cnt_q  <= reload_q;
            tick_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
      end
    end
  end
endmodule

module baud_frac_gen_chk #(
  parameter int CNT_W  = 13,
  parameter int FRAC_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              frac,
  input logic [CNT_W-1:0]  reload,
  input logic [FRAC_W-1:0] fdv,
  input logic              tick
);
  p_quiet_when_stopped_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !tick);
  p_reload_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> $stable(reload));
  p_single_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !frac && run) |=> !tick);
  p_zero_fdv_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && frac && fdv == '0) |=> !tick);
  always @(posedge clk)
    if (!rst_n) p_reset_quiet_r1: assert (!tick);
endmodule

bind baud_frac_gen baud_frac_gen_chk #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run_q), .frac(frac_q),
  .reload(reload_q), .fdv(fdv_q), .tick(tick)
);

// File: tb/baud_frac_gen_bench.sv
module baud_frac_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        tick;
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  baud_frac_gen u_baud_frac_gen (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .tick(tick)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // returns the number of negedges until tick is seen high (0 if none in lim)
  task automatic wait_tick(input int lim, output int n);
    n = 0;
    for (int k = 1; k <= lim; k++) begin
      @(negedge clk);
      if (tick) begin n = k; break; end
    end
  endtask

  task automatic start(input bit frac, input bit div3, input int reload, output int first);
    wr(2'd0, 16'd0);
    wr(2'd1, reload[15:0]);
    wr(2'd0, {13'd0, frac, div3, 1'b1});
    wait_tick(40000, first);
  endtask

  task automatic t_reset;
    int first, gap;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(tick == 1'b0, "R1 idle", tick, 0);
    end
    wr(2'd0, 16'd1);
    wait_tick(100, first);
    check(first == 2, "R1 first tick", first, 2);
    wait_tick(100, gap);
    check(gap == 2, "R1 gap", gap, 2);
  endtask

  task automatic t_div2;
    int first, gap;
    start(1'b0, 1'b0, 4, first);
    check(first == 10, "R7 first div2", first, 10);
    for (int k = 0; k < 3; k++) begin
      wait_tick(100, gap);
      check(gap == 10, "R2 gap div2", gap, 10);
    end
  endtask

  task automatic t_div3;
    int first, gap;
    start(1'b0, 1'b1, 4, first);
    check(first == 15, "R7 first div3", first, 15);
    wait_tick(100, gap);
    check(gap == 15, "R3 gap div3", gap, 15);
    @(negedge clk);
    check(tick == 1'b0, "R8 width", tick, 0);
    wait_tick(100, gap);
    check(gap == 14, "R8 next gap", gap, 14);
  endtask

  task automatic t_frac;
    int first, gap;
    wr(2'd2, 16'd4096);
    start(1'b1, 1'b0, 3, first);
    for (int k = 0; k < 3; k++) begin
      wait_tick(100, gap);
      check(gap == 8, "R4 half rate", gap, 8);
    end
    wr(2'd2, 16'd6144);
    start(1'b1, 1'b0, 2, first);
    for (int k = 0; k < 4; k++) begin
      wait_tick(100, gap);
      check(gap == 4, "R4 three quarter rate", gap, 4);
    end
    wr(2'd2, 16'd0);
    start(1'b1, 1'b0, 0, first);
    check(first == 0, "R4 zero fdv silent", first, 0);
  endtask

  task automatic t_ignore;
    int first, gap;
    start(1'b0, 1'b0, 4, first);
    wr(2'd1, 16'd1);
    wait_tick(100, gap);
    wait_tick(100, gap);
    check(gap == 10, "R5 running gap", gap, 10);
    start(1'b0, 1'b0, 4, first);
    wr(2'd1, 16'd1);
    wr(2'd0, 16'd0);
    wr(2'd0, 16'd1);
    wait_tick(100, first);
    check(first == 10, "R5 after restart", first, 10);
    start(1'b0, 1'b0, 1, first);
    check(first == 4, "R5 write while stopped", first, 4);
  endtask

  task automatic t_stop;
    int first;
    bit seen = 0;
    start(1'b0, 1'b1, 3, first);
    repeat (5) @(negedge clk);
    wr(2'd0, 16'd2);
    for (int k = 0; k < 50; k++) begin
      @(negedge clk);
      if (tick) seen = 1;
    end
    check(seen == 0, "R6 stopped quiet", seen, 0);
    wr(2'd0, 16'd3);
    wait_tick(100, first);
    check(first == 12, "R6 clean restart", first, 12);
  endtask

  task automatic t_max;
    int first, gap;
    start(1'b0, 1'b0, 16'hFFFF, first);
    check(first == 16384, "R9 max reload first", first, 16384);
    wait_tick(20000, gap);
    check(gap == 16384, "R9 max reload gap", gap, 16384);
  endtask

  initial begin
    #(8 * 200000);
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(tick == 1'b0, "R1 in reset", tick, 0);
    rst_n = 1'b1;
    t_reset();
    t_div2();
    t_div3();
    t_frac();
    t_ignore();
    t_stop();
    t_max();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule